// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block is the digital controller for an analog-to-digital converter that works through a contiguous range of channel indices. For each channel it first holds a sampling phase of a fixed number of cycles, then a conversion phase. The conversion phase lasts until the analog core reports completion with a one-cycle `conv_done` pulse and a data word. The analog core itself is outside the block. The controller drives `samp_en`, `conv_en` and `chan_sel` to the analog core and takes its `conv_done` and `conv_data` in return.

Every finished channel writes its data word into one shared result register and raises a completion flag. Software reads the result over a small register bus, and that read lowers the completion flag. If a new result arrives before the previous one has been read, the result register is still overwritten, and a sticky overwrite flag records the lost data. Software clears that flag by writing 1 to its bit. Each flag can drive its own interrupt line through an enable bit.

The block runs in one of two modes. In one-shot mode it scans the range once and then stops by itself. In continuous mode it loops over the range until software writes 0 to the run bit. That write abandons the conversion in progress, and the result of that conversion is never stored.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset the block is idle, `samp_en`, `conv_en`, `irq_done` and `irq_ovr` are low, and the control, range and result registers all read 0.
- R2: Writing 1 to the run bit while idle starts a scan at the start channel. Each channel is presented on `chan_sel` with `samp_en` high for exactly SAMPLE_CYCLES cycles, then `conv_en` high until `conv_done` arrives. Channels are visited in increasing order (modulo 2^CH_W) up to the end channel.
- R3: A `conv_done` pulse during the conversion phase stores `conv_data` in the result register and sets the completion flag on the next clock edge.
- R4: A bus read of the result register clears the completion flag. When that read falls in the same cycle as a completion, the completion wins and the flag stays set.
- R5: A completion that arrives while the completion flag is set, with no result read in the same cycle, still overwrites the result register. In that case the overwrite flag and the completion flag are both set.
- R6: The overwrite flag stays set until a control-register write with bit 3 at 1. Reads of the result register do not clear it.
- R7: In one-shot mode the block goes idle after the end channel completes, and the run bit then reads 0.
- R8: In continuous mode the scan wraps from the end channel back to the start channel without stopping. A set overwrite flag neither stops nor delays the scan.
- R9: Writing 0 to the run bit while busy stops the scan on the next edge, with `samp_en` and `conv_en` low. A `conv_done` in the same cycle as that write, or any later one, changes neither the result nor the flags.
- R10: When the start and end channels are equal, only that channel is converted: once in one-shot mode, repeatedly in continuous mode.
- R11: `irq_done` is high exactly when the completion flag and its enable are both set. `irq_ovr` is high exactly when the overwrite flag and its enable are both set.
- R12: Register map. Address 0 is control, with bit 0 run/busy, bit 1 continuous mode, bit 2 completion flag (read-only), bit 3 overwrite flag (write 1 to clear), bit 4 completion interrupt enable and bit 5 overwrite interrupt enable. Address 1 is the range, with start channel in bits 2:0 and end channel in bits 6:4. Address 2 is the result. Address 3 and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| samp_en | output | 1 | Sampling phase active |
| conv_en | output | 1 | Conversion phase active |
| chan_sel | output | CH_W | Channel being sampled or converted |
| conv_done | input | 1 | One-cycle conversion-finished pulse from the analog core |
| conv_data | input | DATA_W | Converted value, valid with `conv_done` |
| irq_done | output | 1 | Completion interrupt request |
| irq_ovr | output | 1 | Overwrite interrupt request |

## Verification
The bench times a result read into the exact cycle of a completion. A design that let the read win would drop the completion flag, and one that treated the case as an overwrite would raise a false error. A continuous scan left unread must keep wrapping with the overwrite flag set, which catches a design that stalls or stops on the error. A forced stop lands while the stand-in core is still converting, and the core's pulse is released afterwards. A design that stored that late result, or did not go idle at once, changes the result register or keeps an enable high. A single-channel range catches off-by-one errors at the end channel and in the wrap.

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int ADDR_W        = 2,
  parameter int DATA_W        = 16,
  parameter int CH_W          = 3,
  parameter int SAMPLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              samp_en,
  output logic              conv_en,
  output logic [CH_W-1:0]   chan_sel,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              irq_done,
  output logic              irq_ovr
);

  localparam int CNT_W   = (SAMPLE_CYCLES > 1) ? $clog2(SAMPLE_CYCLES) : 1;
  localparam int END_LSB = CH_W + 1;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RANGE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_RES   = ADDR_W'(2);
  localparam logic [CNT_W-1:0]  SAMP_LAST = CNT_W'(SAMPLE_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_SAMP, S_CONV} state_t;

  state_t            st;
  logic [CH_W-1:0]   ch, first_ch, last_ch;
  logic [CNT_W-1:0]  cnt;
  logic              cont_mode, done_f, ovr_f, done_ie, ovr_ie;
  logic [DATA_W-1:0] result;

  logic wr_ctrl, wr_range, rd_result, busy, abort, launch, finish;
  logic unused_wbits;

  assign wr_ctrl   = bus_sel & bus_wr & (bus_addr == A_CTRL);
  assign wr_range  = bus_sel & bus_wr & (bus_addr == A_RANGE);
  assign rd_result = bus_sel & ~bus_wr & (bus_addr == A_RES);
  assign busy      = (st != S_IDLE);
  assign abort     = wr_ctrl & ~bus_wdata[0] & busy;
  assign launch    = wr_ctrl & bus_wdata[0] & ~busy;
  assign finish    = (st == S_CONV) & conv_done & ~abort;
  assign unused_wbits = ^bus_wdata[DATA_W-1:END_LSB+CH_W];

  assign samp_en  = (st == S_SAMP);
  assign conv_en  = (st == S_CONV);
  assign chan_sel = ch;
  assign irq_done = done_f & done_ie;
  assign irq_ovr  = ovr_f & ovr_ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      ch  <= '0;
      cnt <= '0;
    end else if (abort) begin
      st <= S_IDLE;
    end else if (launch) begin
      st  <= S_SAMP;
      ch  <= first_ch;
      cnt <= '0;
    end else begin
      case (st)
        S_SAMP: begin
          if (cnt == SAMP_LAST) st <= S_CONV;
          else                  cnt <= cnt + 1'b1;
        end
        S_CONV: begin
          if (finish) begin
            cnt <= '0;
            if (ch == last_ch) begin
              if (cont_mode) begin
                ch <= first_ch;
                st <= S_SAMP;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              ch <= ch + 1'b1;
              st <= S_SAMP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      done_f <= 1'b0;
      ovr_f  <= 1'b0;
    end else begin
      if (finish) begin
        result <= conv_data;
        done_f <= 1'b1;
      end else if (rd_result) begin
        done_f <= 1'b0;
      end
      if (finish && done_f && !rd_result) ovr_f <= 1'b1;
      else if (wr_ctrl && bus_wdata[3])    ovr_f <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cont_mode <= 1'b0;
      done_ie   <= 1'b0;
      ovr_ie    <= 1'b0;
      first_ch  <= '0;
      last_ch   <= '0;
    end else begin
      if (wr_ctrl) begin
        cont_mode <= bus_wdata[1];
        done_ie   <= bus_wdata[4];
        ovr_ie    <= bus_wdata[5];
      end
      if (wr_range) begin
        first_ch <= bus_wdata[CH_W-1:0];
        last_ch  <= bus_wdata[END_LSB +: CH_W];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[0] = busy;
        bus_rdata[1] = cont_mode;
        bus_rdata[2] = done_f;
        bus_rdata[3] = ovr_f;
        bus_rdata[4] = done_ie;
        bus_rdata[5] = ovr_ie;
      end
      A_RANGE: begin
        bus_rdata[CH_W-1:0]        = first_ch;
        bus_rdata[END_LSB +: CH_W] = last_ch;
      end
      A_RES:   bus_rdata = result;
      default: ;
    endcase
  end

endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wd_run,
  input logic              wd_ovrclr,
  input logic              samp_en,
  input logic              conv_en,
  input logic              conv_done,
  input logic [DATA_W-1:0] conv_data,
  input logic              irq_done,
  input logic              irq_ovr,
  input logic              done_f,
  input logic              ovr_f,
  input logic [DATA_W-1:0] result
);

  logic wr_c, rd_r, stop_req, comp;
  assign wr_c     = bus_sel && bus_wr && (bus_addr == ADDR_W'(0));
  assign rd_r     = bus_sel && !bus_wr && (bus_addr == ADDR_W'(2));
  assign stop_req = wr_c && !wd_run;
  assign comp     = conv_en && conv_done && !stop_req;

  // R2
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(samp_en && conv_en));

  // R3
  result_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comp |=> (done_f && result == $past(conv_data)));

  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_r && !comp) |=> !done_f);

  // R4
  collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_r && comp) |=> (done_f && $stable(ovr_f)));

  // R5
  overwrite_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (comp && done_f && !rd_r) |=> (ovr_f && done_f));

  // R6
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_f && !(wr_c && wd_ovrclr)) |=> ovr_f);

  // R9
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && (samp_en || conv_en)) |=> (!samp_en && !conv_en && $stable(result)));

  // R11
  irq_done_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> done_f);

  // R11
  irq_ovr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovr |-> ovr_f);

endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wd_run(bus_wdata[0]), .wd_ovrclr(bus_wdata[3]),
  .samp_en(samp_en), .conv_en(conv_en), .conv_done(conv_done), .conv_data(conv_data),
  .irq_done(irq_done), .irq_ovr(irq_ovr), .done_f(done_f), .ovr_f(ovr_f), .result(result)
);

// File: tb/tb_adc_scan_ctrl.sv
module tb_adc_scan_ctrl;
  localparam int SAMP = 4;
  localparam int LAT  = 3;

  logic clk = 0, rst_n = 0;
  logic t_sel = 0, t_wr = 0, coll_rd = 0;
  logic [1:0] t_addr = 0;
  logic [15:0] t_wdata = 0;
  logic bus_sel, bus_wr;
  logic [1:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata, conv_data;
  logic samp_en, conv_en, conv_done, irq_done, irq_ovr;
  logic [2:0] chan_sel;

  assign bus_sel   = t_sel | coll_rd;
  assign bus_wr    = t_wr & ~coll_rd;
  assign bus_addr  = coll_rd ? 2'd2 : t_addr;
  assign bus_wdata = t_wdata;

  always #5 clk = ~clk;

  adc_scan_ctrl #(.SAMPLE_CYCLES(SAMP)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .samp_en(samp_en), .conv_en(conv_en),
    .chan_sel(chan_sel), .conv_done(conv_done), .conv_data(conv_data),
    .irq_done(irq_done), .irq_ovr(irq_ovr));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit model_on = 0, stall = 0, collide = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // analog stand-in
  int lat_cnt = 0, seq = 0;
  logic [15:0] last_data = 0;
  int fired[$];
  initial begin conv_done = 0; conv_data = 0; end
  always @(negedge clk) begin
    conv_done = 0;
    coll_rd = 0;
    if (conv_en) begin
      if (lat_cnt == LAT) begin
        if (!stall) begin
          conv_done = 1;
          conv_data = 16'hA000 | (16'(chan_sel) << 8) | 16'(seq[7:0]);
          last_data = conv_data;
          seq++;
          fired.push_back(int'(chan_sel));
          coll_rd = collide;
          lat_cnt = 0;
        end
      end else lat_cnt++;
    end else lat_cnt = 0;
  end

  // behavioural reference model
  int m_ph = 0, m_cnt = 0;
  logic [2:0] m_ch = 0, m_first = 0, m_last = 0;
  logic m_cont = 0, m_done = 0, m_ovr = 0, m_ie = 0, m_oe = 0;
  logic [15:0] m_res = 0;

  always @(posedge clk) begin : mdl
    bit wc, wrg, rr, bz, ab, go, fin;
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_ch = 0; m_first = 0; m_last = 0;
      m_cont = 0; m_done = 0; m_ovr = 0; m_ie = 0; m_oe = 0; m_res = 0;
    end else begin
      wc  = bus_sel && bus_wr && bus_addr == 2'd0;
      wrg = bus_sel && bus_wr && bus_addr == 2'd1;
      rr  = bus_sel && !bus_wr && bus_addr == 2'd2;
      bz  = m_ph != 0;
      ab  = wc && !bus_wdata[0] && bz;
      go  = wc && bus_wdata[0] && !bz;
      fin = (m_ph == 2) && conv_done && !ab;
      if (fin && m_done && !rr) m_ovr = 1;
      else if (wc && bus_wdata[3]) m_ovr = 0;
      if (fin) begin m_done = 1; m_res = conv_data; end
      else if (rr) m_done = 0;
      if (ab) m_ph = 0;
      else if (go) begin m_ph = 1; m_ch = m_first; m_cnt = 0; end
      else if (m_ph == 1) begin
        if (m_cnt == SAMP - 1) m_ph = 2; else m_cnt++;
      end else if (fin) begin
        m_cnt = 0;
        if (m_ch == m_last) begin
          if (m_cont) begin m_ch = m_first; m_ph = 1; end else m_ph = 0;
        end else begin m_ch = m_ch + 1; m_ph = 1; end
      end
      if (wc) begin m_cont = bus_wdata[1]; m_ie = bus_wdata[4]; m_oe = bus_wdata[5]; end
      if (wrg) begin m_first = bus_wdata[2:0]; m_last = bus_wdata[6:4]; end
    end
  end

  function automatic logic [15:0] m_rd(input logic [1:0] a);
    case (a)
      2'd0: return {10'd0, m_oe, m_ie, m_ovr, m_done, m_cont, logic'(m_ph != 0)};
      2'd1: return {9'd0, m_last, 1'b0, m_first};
      2'd2: return m_res;
      default: return 16'd0;
    endcase
  endfunction

  int samp_run = 0;
  int samp_lens[$];
  always @(posedge clk) begin
    #2;
    if (model_on && rst_n) begin
      chk(samp_en == (m_ph == 1) && conv_en == (m_ph == 2) && chan_sel == m_ch,
          "R2 phase/channel vs model", {samp_en, conv_en, chan_sel}, {logic'(m_ph == 1), logic'(m_ph == 2), m_ch});
      chk(irq_done == (m_done && m_ie) && irq_ovr == (m_ovr && m_oe),
          "R11 irq vs model", {irq_done, irq_ovr}, {m_done && m_ie, m_ovr && m_oe});
      chk(bus_rdata == m_rd(bus_addr), "R12 rdata vs model", bus_rdata, m_rd(bus_addr));
      if (samp_en) samp_run++;
      else if (samp_run > 0) begin samp_lens.push_back(samp_run); samp_run = 0; end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); t_sel = 1; t_wr = 1; t_addr = a; t_wdata = d;
    @(negedge clk); t_sel = 0; t_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); t_sel = 1; t_wr = 0; t_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); t_sel = 0;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 2000; i++) begin
      bus_read(2'd0, v);
      if (!v[0]) return;
    end
  endtask

  task automatic check_fired(input int exp[$], input string tag);
    chk(fired.size() == exp.size(), tag, fired.size(), exp.size());
    if (fired.size() == exp.size())
      for (int i = 0; i < exp.size(); i++) chk(fired[i] == exp[i], tag, fired[i], exp[i]);
  endtask

  initial begin
    logic [15:0] v, keep;
    int nf;
    repeat (4) @(negedge clk);
    rst_n = 1;
    model_on = 1;
    // R1 reset state
    bus_read(2'd0, v); chk(v == 0, "R1 ctrl after reset", v, 0);
    bus_read(2'd1, v); chk(v == 0, "R1 range after reset", v, 0);
    bus_read(2'd2, v); chk(v == 0, "R1 result after reset", v, 0);
    chk(!samp_en && !conv_en && !irq_done && !irq_ovr, "R1 outputs low", {samp_en, conv_en, irq_done, irq_ovr}, 0);

    // R12 map
    bus_write(2'd1, 16'h0042);
    bus_read(2'd1, v); chk(v == 16'h0042, "R12 range readback", v, 16'h0042);
    bus_read(2'd3, v); chk(v == 0, "R12 unused address", v, 0);

    // R2 / R7 one-shot 2..4, no reads
    fired.delete(); samp_lens.delete();
    bus_write(2'd0, 16'h0001);
    wait_idle();
    check_fired('{2, 3, 4}, "R2 one-shot scan order");
    chk(samp_lens.size() == 3, "R2 sample phase count", samp_lens.size(), 3);
    foreach (samp_lens[i]) chk(samp_lens[i] == SAMP, "R2 sample phase length", samp_lens[i], SAMP);
    bus_read(2'd0, v);
    chk(v[0] == 0, "R7 run bit cleared", v[0], 0);
    chk(v[2] == 1, "R3 completion flag set", v[2], 1);
    chk(v[3] == 1, "R5 overwrite flag set", v[3], 1);
    bus_read(2'd2, v); chk(v == last_data, "R3/R5 result is newest data", v, last_data);
    bus_read(2'd0, v);
    chk(v[2] == 0, "R4 read clears completion", v[2], 0);
    chk(v[3] == 1, "R6 overwrite survives result read", v[3], 1);
    bus_write(2'd0, 16'h0008);
    bus_read(2'd0, v); chk(v[3] == 0, "R6 write-one clears overwrite", v[3], 0);

    // R10 single channel one-shot
    fired.delete();
    bus_write(2'd1, 16'h0066);
    bus_write(2'd0, 16'h0001);
    wait_idle();
    check_fired('{6}, "R10 single channel once");
    bus_read(2'd0, v);
    chk(v[2] == 1 && v[3] == 0, "R10 one result no overwrite", v, 16'h0004);

    // R11 interrupt gating
    bus_write(2'd0, 16'h0030);
    @(negedge clk);
    chk(irq_done == 1 && irq_ovr == 0, "R11 irq with enables", {irq_done, irq_ovr}, 2'b10);
    bus_read(2'd2, v);
    @(negedge clk);
    chk(irq_done == 0, "R11 irq drops with flag", irq_done, 0);

    // R8 continuous 5..7, unread
    fired.delete();
    bus_write(2'd1, 16'h0075);
    bus_write(2'd0, 16'h0023);
    while (fired.size() < 7) @(posedge clk);
    check_fired('{5, 6, 7, 5, 6, 7, 5}, "R8 continuous wrap");
    bus_read(2'd0, v);
    chk(v[0] == 1 && v[3] == 1, "R8 still running with overwrite", v[3:0], 4'b1111);
    chk(irq_ovr == 1, "R11 overwrite irq", irq_ovr, 1);

    // R9 forced stop mid-conversion
    @(posedge clk); stall = 1;
    while (!conv_en) @(posedge clk);
    bus_read(2'd2, keep);
    bus_write(2'd0, 16'h0000);
    chk(!samp_en && !conv_en, "R9 stopped", {samp_en, conv_en}, 0);
    nf = fired.size();
    @(posedge clk); stall = 0;
    repeat (12) @(negedge clk);
    bus_read(2'd2, v); chk(v == keep, "R9 result untouched", v, keep);
    chk(fired.size() == nf, "R9 no further conversions", fired.size(), nf);
    bus_read(2'd0, v); chk(v[0] == 0, "R9 run bit reads 0", v[0], 0);

    // R4/R5 read colliding with completion, continuous single channel
    bus_write(2'd0, 16'h0008);
    bus_read(2'd2, v);
    fired.delete();
    bus_write(2'd1, 16'h0033);
    @(posedge clk); collide = 1;
    bus_write(2'd0, 16'h0003);
    while (fired.size() < 3) @(posedge clk);
    @(posedge clk); collide = 0;
    bus_read(2'd0, v);
    chk(v[2] == 1, "R4 completion beats same-cycle read", v[2], 1);
    chk(v[3] == 0, "R5 no overwrite when read coincides", v[3], 0);
    check_fired('{3, 3, 3}, "R10 single channel repeats");
    bus_write(2'd0, 16'h0000);
    repeat (4) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule